// File: doc/BRIEF.md
# Word-Copy DMA Channel

This block is a single DMA channel that copies a run of 32-bit words from one memory address to another without processor involvement. Software sets up a source address, a destination address and a control word through a small register port. It then writes a byte count, and the channel starts. For each word the channel issues a read request, waits for the response, then issues a write request carrying the word it read, and waits again. Either side can keep its address fixed instead of stepping through memory, so the channel can drain or fill a FIFO-style device port.

The memory port is word-wide and simple. A request (`mem_req`, `mem_we`, `mem_addr`, `mem_wdata`) is held until a single-cycle response (`mem_rsp`) arrives. The response carries read data and an error flag. A software-set limit bounds how long the channel waits for any one response. Completion and failures are latched in an interrupt status register. That register is masked by an enable register and collapsed onto one `irq` line.

Register offsets are byte offsets on `reg_addr`: control 0x00, status 0x04, source 0x08, destination 0x0C, length 0x10, interrupt status 0x14, interrupt enable 0x18, wait limit 0x1C, software reset 0x20. Any other offset reads as zero. Registers are written when `reg_we` is high at a rising edge. `reg_rdata` is a combinational function of `reg_addr` and the current register state.

Top module: `dma_word_channel`

## Requirements
- R1: After `rst_n` is released, every register reads zero, `mem_req` is low and `irq` is low.
- R2: While idle, writing the length register (0x10) with a value whose word count (bits [15:2]) is nonzero starts a transfer of that many words.
  - The transfer uses the programmed source, destination and control values.
  - `mem_req` rises in the cycle after the write edge.
  - Each word is one read request followed by one write request of the word just read.
  - A request holds its address and direction until its response.
- R3: Control bit 31 set makes the source address advance by 4 after each word. When it is clear, every read uses the programmed source address.
- R4: Control bit 30 set makes the destination address advance by 4 after each word. When it is clear, every write uses the programmed destination address.
- R5: Status bit 31 reads 1 while a transfer is active. At the edge that accepts the final write response, busy clears and interrupt status bit 0 (done) sets.
- R6: A response with `mem_rsp_err` high aborts the transfer. It sets status bit 30 (bus error) and interrupt status bit 1 (error).
- R7: When the wait limit (0x1C, bits [15:0]) is nonzero and a request sees that many consecutive cycles without a response, the channel aborts in the last of those cycles. It then sets status bit 29 (timeout) and interrupt status bit 1. A response in that last cycle is still accepted. A limit of zero disables the timeout.
- R8: Writing a 1 to an interrupt status bit (0x14) clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some interrupt status bit and the matching interrupt enable bit (0x18, bits [1:0]) are both set.
- R10: Any write to 0x20 aborts an active transfer, drops `mem_req` at the next edge and returns every register to zero.
- R11: A length write made while busy, or one whose word count is zero, starts nothing and leaves the length register unchanged.
- R12: Starting a transfer clears status bits 30 and 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Masked interrupt request |
| mem_req | output | 1 | Memory request valid, held until response |
| mem_we | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | 32 | Word-aligned byte address of the request |
| mem_wdata | output | 32 | Write data for a write request |
| mem_rsp | input | 1 | Single-cycle response to the pending request |
| mem_rsp_err | input | 1 | Response reports a bus error |
| mem_rdata | input | 32 | Read data with the response |

## Verification
All state changes take effect on one rising edge.
- The first request is visible in the cycle right after the length write.
- A response sampled at an edge moves the request on, or drops it, in the cycle that follows.
- Done, error and timeout appear in the status and interrupt registers, and on `irq`, in the cycle right after the edge that caused them.

The bench drives inputs on the falling edge. A behavioural model advances on the rising edge. On every falling edge the model's predicted request, address, direction, write data and `irq` are compared with the outputs, half a cycle after the edge that produced them. Register reads are sampled once `reg_addr` has settled.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int DATA_W     = 32;
    localparam int REG_AW     = 6;
    localparam int WORD_BYTES = 4;
    localparam int IRQ_W      = 2;

    localparam logic [REG_AW-1:0] OFS_CTRL = 6'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 6'h04;
    localparam logic [REG_AW-1:0] OFS_SRC  = 6'h08;
    localparam logic [REG_AW-1:0] OFS_DST  = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_LEN  = 6'h10;
    localparam logic [REG_AW-1:0] OFS_ISR  = 6'h14;
    localparam logic [REG_AW-1:0] OFS_IER  = 6'h18;
    localparam logic [REG_AW-1:0] OFS_TLIM = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_SRST = 6'h20;

    localparam int CTRL_SRC_INC = 31;
    localparam int CTRL_DST_INC = 30;
    localparam int STAT_BUSY    = 31;
    localparam int STAT_BERR    = 30;
    localparam int STAT_TOUT    = 29;
    localparam int IRQ_DONE     = 0;
    localparam int IRQ_ERR      = 1;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_state_e;

endpackage

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 14,
    parameter int TOUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start,
    input  logic              src_inc,
    input  logic              dst_inc,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic [TOUT_W-1:0] tout_limit,
    input  logic              mem_rsp,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done_evt,
    output logic              berr_evt,
    output logic              tout_evt
);

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [TOUT_W-1:0] TOUT_ONE = TOUT_W'(1);

    typedef struct packed {
        eng_state_e        state;
        logic              src_inc;
        logic              dst_inc;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  left;
        logic [TOUT_W-1:0] wait_cnt;
        logic [DATA_W-1:0] data;
    } eng_s;

    eng_s eng_d, eng_q;

    always_comb begin
        eng_d    = eng_q;
        done_evt = 1'b0;
        berr_evt = 1'b0;
        tout_evt = 1'b0;
        case (eng_q.state)
            ENG_IDLE: begin
                if (start) begin
                    eng_d.state    = ENG_READ;
                    eng_d.src_inc  = src_inc;
                    eng_d.dst_inc  = dst_inc;
                    eng_d.src      = src_base;
                    eng_d.dst      = dst_base;
                    eng_d.left     = word_cnt;
                    eng_d.wait_cnt = '0;
                end
            end
            ENG_READ, ENG_WRITE: begin
                if (mem_rsp) begin
                    eng_d.wait_cnt = '0;
                    if (mem_rsp_err) begin
                        berr_evt    = 1'b1;
                        eng_d.state = ENG_IDLE;
                    end else if (eng_q.state == ENG_READ) begin
                        eng_d.data  = mem_rdata;
                        eng_d.state = ENG_WRITE;
                    end else begin
                        eng_d.left = eng_q.left - CNT_ONE;
                        if (eng_q.src_inc) eng_d.src = eng_q.src + STEP;
                        if (eng_q.dst_inc) eng_d.dst = eng_q.dst + STEP;
                        if (eng_q.left == CNT_ONE) begin
                            eng_d.state = ENG_IDLE;
                            done_evt    = 1'b1;
                        end else begin
                            eng_d.state = ENG_READ;
                        end
                    end
                end else if ((tout_limit != '0) &&
                             (eng_q.wait_cnt == tout_limit - TOUT_ONE)) begin
                    tout_evt    = 1'b1;
                    eng_d.state = ENG_IDLE;
                end else begin
                    eng_d.wait_cnt = eng_q.wait_cnt + TOUT_ONE;
                end
            end
            default: eng_d.state = ENG_IDLE;
        endcase
        if (soft_rst) begin
            eng_d    = '0;
            done_evt = 1'b0;
            berr_evt = 1'b0;
            tout_evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy      = (eng_q.state != ENG_IDLE);
    assign mem_req   = busy;
    assign mem_we    = (eng_q.state == ENG_WRITE);
    assign mem_addr  = mem_we ? eng_q.dst : eng_q.src;
    assign mem_wdata = eng_q.data;

    // R2: a pending request stays put until answered
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp && !tout_evt && !soft_rst)
        |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: the register side only issues a start while the engine is idle
    a_r11_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R5: completion only on an error-free write response
    a_r5_done_on_write_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> (mem_req && mem_we && mem_rsp && !mem_rsp_err));

    // R6: an error response ends the transfer
    a_r6_err_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rsp && mem_rsp_err && !soft_rst) |=> !mem_req);

    // R7: timeout only while a request is outstanding and unanswered
    a_r7_tout_needs_silence: assert property (@(posedge clk) disable iff (!rst_n)
        tout_evt |-> (mem_req && !mem_rsp));

    // R10: software reset stops the memory side
    a_r10_soft_idles: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !mem_req);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int TOUT_W = 16,
    localparam int CNT_W = LEN_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              busy,
    input  logic              done_evt,
    input  logic              berr_evt,
    input  logic              tout_evt,
    output logic              soft_rst,
    output logic              start,
    output logic              src_inc,
    output logic              dst_inc,
    output logic [ADDR_W-1:0] src_base,
    output logic [ADDR_W-1:0] dst_base,
    output logic [CNT_W-1:0]  word_cnt,
    output logic [TOUT_W-1:0] tout_limit
);

    typedef struct packed {
        logic              src_inc;
        logic              dst_inc;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic              berr;
        logic              tout;
        logic [IRQ_W-1:0]  isr;
        logic [IRQ_W-1:0]  ier;
        logic [TOUT_W-1:0] tlim;
    } regs_s;

    regs_s regs_d, regs_q;

    assign word_cnt = reg_wdata[LEN_W-1:2];
    assign soft_rst = reg_we && (reg_addr == OFS_SRST);
    assign start    = reg_we && (reg_addr == OFS_LEN) && !busy && (word_cnt != '0);

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            case (reg_addr)
                OFS_CTRL: begin
                    regs_d.src_inc = reg_wdata[CTRL_SRC_INC];
                    regs_d.dst_inc = reg_wdata[CTRL_DST_INC];
                end
                OFS_SRC:  regs_d.src  = reg_wdata[ADDR_W-1:0];
                OFS_DST:  regs_d.dst  = reg_wdata[ADDR_W-1:0];
                OFS_LEN: begin
                    if (start) begin
                        regs_d.len  = reg_wdata[LEN_W-1:0];
                        regs_d.berr = 1'b0;
                        regs_d.tout = 1'b0;
                    end
                end
                OFS_ISR:  regs_d.isr  = regs_q.isr & ~reg_wdata[IRQ_W-1:0];
                OFS_IER:  regs_d.ier  = reg_wdata[IRQ_W-1:0];
                OFS_TLIM: regs_d.tlim = reg_wdata[TOUT_W-1:0];
                default: ;
            endcase
        end
        if (berr_evt) regs_d.berr = 1'b1;
        if (tout_evt) regs_d.tout = 1'b1;
        if (done_evt) regs_d.isr[IRQ_DONE] = 1'b1;
        if (berr_evt || tout_evt) regs_d.isr[IRQ_ERR] = 1'b1;
        if (soft_rst) regs_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTRL_SRC_INC] = regs_q.src_inc;
                reg_rdata[CTRL_DST_INC] = regs_q.dst_inc;
            end
            OFS_STAT: begin
                reg_rdata[STAT_BUSY] = busy;
                reg_rdata[STAT_BERR] = regs_q.berr;
                reg_rdata[STAT_TOUT] = regs_q.tout;
            end
            OFS_SRC:  reg_rdata = DATA_W'(regs_q.src);
            OFS_DST:  reg_rdata = DATA_W'(regs_q.dst);
            OFS_LEN:  reg_rdata = DATA_W'(regs_q.len);
            OFS_ISR:  reg_rdata = DATA_W'(regs_q.isr);
            OFS_IER:  reg_rdata = DATA_W'(regs_q.ier);
            OFS_TLIM: reg_rdata = DATA_W'(regs_q.tlim);
            default: ;
        endcase
    end

    assign irq        = |(regs_q.isr & regs_q.ier);
    assign src_inc    = regs_q.src_inc;
    assign dst_inc    = regs_q.dst_inc;
    assign src_base   = regs_q.src;
    assign dst_base   = regs_q.dst;
    assign tout_limit = regs_q.tlim;

    // R8: a written one clears the done bit when no event competes
    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_ISR && reg_wdata[IRQ_DONE] && !done_evt)
        |=> !regs_q.isr[IRQ_DONE]);

    // R11: a refused length write keeps the stored length
    a_r11_len_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_LEN && !start) |=> $stable(regs_q.len));

    // R12: a start leaves both fault flags clear
    a_r12_start_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !(regs_q.berr || regs_q.tout));

    // R10: software reset empties every register
    a_r10_soft_zero: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs_q == '0));

    // R6/R7: every fault raises the error interrupt bit
    a_r6_fault_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        ((berr_evt || tout_evt) && !soft_rst) |=> regs_q.isr[IRQ_ERR]);

endmodule

// File: rtl/dma_word_channel.sv
module dma_word_channel
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int TOUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp,
    input  logic              mem_rsp_err,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int CNT_W = LEN_W - 2;

    logic              busy, done_evt, berr_evt, tout_evt;
    logic              soft_rst, start, src_inc, dst_inc;
    logic [ADDR_W-1:0] src_base, dst_base;
    logic [CNT_W-1:0]  word_cnt;
    logic [TOUT_W-1:0] tout_limit;

    dma_chan_regs #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .TOUT_W (TOUT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq        (irq),
        .busy       (busy),
        .done_evt   (done_evt),
        .berr_evt   (berr_evt),
        .tout_evt   (tout_evt),
        .soft_rst   (soft_rst),
        .start      (start),
        .src_inc    (src_inc),
        .dst_inc    (dst_inc),
        .src_base   (src_base),
        .dst_base   (dst_base),
        .word_cnt   (word_cnt),
        .tout_limit (tout_limit)
    );

    dma_chan_engine #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .TOUT_W (TOUT_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .start       (start),
        .src_inc     (src_inc),
        .dst_inc     (dst_inc),
        .src_base    (src_base),
        .dst_base    (dst_base),
        .word_cnt    (word_cnt),
        .tout_limit  (tout_limit),
        .mem_rsp     (mem_rsp),
        .mem_rsp_err (mem_rsp_err),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .done_evt    (done_evt),
        .berr_evt    (berr_evt),
        .tout_evt    (tout_evt)
    );

endmodule

// File: tb/dma_word_channel_tb.sv
`timescale 1ns/1ps
module dma_word_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rsp = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    dma_word_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rsp(mem_rsp), .mem_rsp_err(mem_rsp_err),
        .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done_run = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // memory model
    logic [31:0] mem [64];
    int          lat = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          rcnt = 0;

    function automatic logic [31:0] init_word(input int i);
        return 32'h5A00_0000 | (i * 32'h0001_0103);
    endfunction

    // behavioural reference model
    bit          m_busy, m_wr, m_sinc, m_dinc;
    logic [31:0] m_src, m_dst, m_cs, m_cd, m_data;
    int          m_left, m_wait, m_tlim;
    logic [1:0]  m_isr, m_ier;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_wr = 0; m_sinc = 0; m_dinc = 0;
            m_src = 0; m_dst = 0; m_cs = 0; m_cd = 0; m_data = 0;
            m_left = 0; m_wait = 0; m_tlim = 0; m_isr = 0; m_ier = 0;
        end else begin
            bit ev_done, ev_err, was_busy;
            ev_done = 0; ev_err = 0; was_busy = m_busy;
            if (m_busy) begin
                if (mem_rsp) begin
                    m_wait = 0;
                    if (mem_rsp_err) begin
                        m_busy = 0; ev_err = 1;
                    end else if (!m_wr) begin
                        m_data = mem_rdata; m_wr = 1;
                    end else begin
                        m_left--; m_wr = 0;
                        if (m_sinc) m_cs += 4;
                        if (m_dinc) m_cd += 4;
                        if (m_left == 0) begin m_busy = 0; ev_done = 1; end
                    end
                end else if (m_tlim != 0 && m_wait == m_tlim - 1) begin
                    m_busy = 0; ev_err = 1;
                end else begin
                    m_wait++;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    6'h00: begin m_sinc = reg_wdata[31]; m_dinc = reg_wdata[30]; end
                    6'h08: m_src = reg_wdata;
                    6'h0C: m_dst = reg_wdata;
                    6'h10: if (!was_busy && reg_wdata[15:2] != 0) begin
                        m_busy = 1; m_wr = 0; m_wait = 0;
                        m_cs = m_src; m_cd = m_dst; m_left = int'(reg_wdata[15:2]);
                    end
                    6'h14: m_isr = m_isr & ~reg_wdata[1:0];
                    6'h18: m_ier = reg_wdata[1:0];
                    6'h1C: m_tlim = int'(reg_wdata[15:0]);
                    default: ;
                endcase
            end
            m_isr = m_isr | {ev_err, ev_done};
            if (reg_we && reg_addr == 6'h20) begin
                m_busy = 0; m_wr = 0; m_sinc = 0; m_dinc = 0;
                m_src = 0; m_dst = 0; m_left = 0; m_wait = 0; m_tlim = 0;
                m_isr = 0; m_ier = 0;
            end
        end
    end

    // per-cycle comparison, then memory responder, then watchdog
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R2 mem_req", {31'b0, mem_req}, {31'b0, m_busy});
            if (m_busy) begin
                chk("R2 mem_we", {31'b0, mem_we}, {31'b0, m_wr});
                chk("R3/R4 mem_addr", mem_addr, m_wr ? m_cd : m_cs);
                if (m_wr) chk("R2 mem_wdata", mem_wdata, m_data);
            end
            chk("R9 irq", {31'b0, irq}, {31'b0, |(m_isr & m_ier)});
        end
        mem_rsp = 0; mem_rsp_err = 0;
        if (mem_req) begin
            if (rcnt == lat) begin
                mem_rsp = 1;
                mem_rsp_err = (mem_addr == err_addr);
                mem_rdata = mem[mem_addr[7:2]];
                if (mem_we && !mem_rsp_err) mem[mem_addr[7:2]] = mem_wdata;
                rcnt = 0;
            end else begin
                rcnt++;
            end
        end else begin
            rcnt = 0;
        end
        if (cycles > 150000 && !done_run) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            rd(6'h04, s);
            if (!s[31]) return;
        end
    endtask

    task automatic run(input logic [31:0] ctrl, input logic [31:0] s,
                       input logic [31:0] d, input logic [31:0] bytes);
        wr(6'h00, ctrl); wr(6'h08, s); wr(6'h0C, d); wr(6'h10, bytes);
        wait_idle();
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 64; i++) mem[i] = init_word(i);
        repeat (4) @(negedge clk);
        // R1 reset state
        for (int a = 0; a <= 8; a++) begin
            rd(6'(a * 4), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2/R3/R4 both sides increment, zero latency
        wr(6'h18, 32'h3);
        run(32'hC000_0000, 32'h00, 32'h80, 32'd16);
        for (int i = 0; i < 4; i++) chk("R2 copied word", mem[32 + i], init_word(i));
        @(negedge clk);
        rd(6'h14, v); chk("R5 done bit", v, 32'h1);
        chk("R9 irq enabled", {31'b0, irq}, 32'h1);
        rd(6'h04, v); chk("R5 not busy", v, 32'h0);
        wr(6'h14, 32'h1);
        rd(6'h14, v); chk("R8 w1c", v, 32'h0);

        // R3 fixed source
        lat = 2;
        run(32'h4000_0000, 32'h10, 32'hA0, 32'd12);
        for (int i = 0; i < 3; i++) chk("R3 fixed source", mem[40 + i], init_word(4));

        // R4 fixed destination
        run(32'h8000_0000, 32'h20, 32'hC0, 32'd12);
        chk("R4 last word lands", mem[48], init_word(10));
        chk("R4 neighbour untouched", mem[49], init_word(49));

        // R9 masking, R8 writing zero
        @(negedge clk);
        wr(6'h18, 32'h0);
        chk("R9 masked", {31'b0, irq}, 32'h0);
        wr(6'h14, 32'h0);
        rd(6'h14, v); chk("R8 zero write keeps", v, 32'h1);
        wr(6'h18, 32'h1);
        chk("R9 unmasked", {31'b0, irq}, 32'h1);
        wr(6'h14, 32'h3);

        // R11 zero word count
        wr(6'h10, 32'd3);
        repeat (3) @(negedge clk);
        rd(6'h04, v); chk("R11 no start", v, 32'h0);
        rd(6'h10, v); chk("R11 length kept", v, 32'd12);

        // R5 busy, R11 write while busy
        lat = 3;
        wr(6'h00, 32'hC000_0000); wr(6'h08, 32'h00); wr(6'h0C, 32'hE0);
        wr(6'h10, 32'd32);
        rd(6'h04, v); chk("R5 busy bit", v, 32'h8000_0000);
        wr(6'h10, 32'd4);
        rd(6'h10, v); chk("R11 busy length kept", v, 32'd32);
        wait_idle();
        chk("R2 eight words", mem[63], init_word(7));

        // R6 bus error
        wr(6'h14, 32'h3);
        lat = 0; err_addr = 32'h30;
        run(32'hC000_0000, 32'h28, 32'h40, 32'd16);
        @(negedge clk);
        rd(6'h04, v); chk("R6 bus error status", v, 32'h4000_0000);
        rd(6'h14, v); chk("R6 error irq bit", v, 32'h2);
        chk("R6 abort before third write", mem[18], init_word(18));
        wr(6'h14, 32'h3);

        // R12 start clears error
        err_addr = 32'hFFFF_FFFF;
        run(32'hC000_0000, 32'h00, 32'h60, 32'd4);
        rd(6'h04, v); chk("R12 error cleared", v, 32'h0);

        // R7 timeout boundary
        wr(6'h14, 32'h3);
        wr(6'h1C, 32'd5);
        lat = 4;
        run(32'hC000_0000, 32'h00, 32'h70, 32'd8);
        @(negedge clk);
        rd(6'h14, v); chk("R7 limit-1 wait completes", v, 32'h1);
        wr(6'h14, 32'h3);
        lat = 5;
        run(32'hC000_0000, 32'h00, 32'h70, 32'd8);
        @(negedge clk);
        rd(6'h04, v); chk("R7 timeout status", v, 32'h2000_0000);
        rd(6'h14, v); chk("R7 error irq bit", v, 32'h2);
        wr(6'h14, 32'h3);
        wr(6'h1C, 32'd0);
        lat = 12;
        run(32'hC000_0000, 32'h00, 32'h70, 32'd8);
        @(negedge clk);
        rd(6'h04, v); chk("R7 limit zero disables", v, 32'h0);
        rd(6'h14, v); chk("R7 completes without limit", v, 32'h1);

        // R10 soft reset mid transfer
        lat = 3;
        wr(6'h18, 32'h3);
        wr(6'h00, 32'hC000_0000); wr(6'h08, 32'h00); wr(6'h0C, 32'hE0);
        wr(6'h10, 32'd32);
        repeat (6) @(negedge clk);
        wr(6'h20, 32'h1);
        for (int a = 0; a <= 8; a++) begin
            rd(6'(a * 4), v);
            chk("R10 register zero", v, 32'h0);
        end
        chk("R10 mem_req low", {31'b0, mem_req}, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);
        repeat (4) @(negedge clk);

        done_run = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule